// File: doc/BRIEF.md
# Two-Phase Handshake FIFO Control Chain

This block is a first-in, first-out buffer made from a chain of stages. Each stage holds one data word and a single phase bit. All signalling on both ends uses transition (non-return-to-zero) handshakes. A producer announces a word by toggling `in_req`. The chain confirms that it has taken the word by toggling `in_ack`. The chain offers a word to the consumer by toggling `out_req`, and the consumer confirms that it has taken it by toggling `out_ack`. A rising edge and a falling edge count as the same kind of event. One complete transfer is one request toggle followed by one acknowledge toggle.

Each stage's phase bit is a consensus element, emulated as a clocked state bit. Its state machine has two states, `PH_LOW` and `PH_HIGH`:

- Transition `RISE` moves it from `PH_LOW` to `PH_HIGH`. It is taken when both consensus inputs are 1.
- Transition `FALL` moves it from `PH_HIGH` to `PH_LOW`. It is taken when both consensus inputs are 0.
- With any other input pair the state holds.

The two inputs of stage i are:

- the predecessor's phase (for stage 0, `in_req`);
- the inverted phase of the successor (for the last stage, the inverted `out_ack`).

A stage holds a data token when its phase differs from its successor's phase (for the last stage, from `out_ack`). Otherwise it holds a bubble. When a phase bit changes, three things happen in that same clock edge: the stage register loads the predecessor's word, a request toggle goes forward, and an acknowledge toggle goes backward. Tokens move forward into bubbles, and bubbles move backward.

Top module: `mp_chain`

## Requirements
- R1: While `rst_n` is low, every phase bit and every data register is 0. So `in_ack`, `out_req` and `out_data` read 0 and every stage holds a bubble.
- R2: A phase bit rises when both of its consensus inputs are 1, falls when both are 0, and otherwise keeps its value. The inputs are the predecessor phase and the inverted successor phase.
- R3: A stage changes phase only when its predecessor holds a token and the stage itself holds a bubble. Two neighbouring stages never change phase on the same edge.
- R4: When `in_req` differs from `in_ack` and stage 0 holds a bubble, `in_ack` toggles on the next clock edge. This applies to request toggles in either direction.
- R5: In an empty chain of N stages, a word moves one stage per edge. `out_req` toggles N edges after the edge that first samples the `in_req` toggle.
- R6: While `out_req` differs from `out_ack` (a word is on offer), `out_req` and `out_data` stay unchanged.
- R7: With N words held and none taken, a pending request is not acknowledged and `in_ack` stays unchanged. The capacity is exactly N words.
- R8: With no word held, `out_req` never toggles.
- R9: Words leave the chain in the order they were accepted, each with the value it had on entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which every phase bit and data register updates |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Producer request; a toggle offers `in_data` |
| in_data | input | WIDTH | Word offered by the producer, held until acknowledged |
| in_ack | output | 1 | Acknowledge to the producer; a toggle means the word was taken |
| out_req | output | 1 | Request to the consumer; a toggle offers `out_data` |
| out_data | output | WIDTH | Word on offer to the consumer |
| out_ack | input | 1 | Consumer acknowledge; a toggle means the offered word was taken |

## Verification
The bench runs these corner cases against a token-and-bubble reference model that it checks on every cycle:

- An empty chain with a consumer waiting. A stage that fired on a stale phase comparison would emit a spurious `out_req` toggle.
- A single word, timed through the whole chain. An extra or missing register on the stage path would shift the N-edge latency.
- A second word whose request toggle is falling rather than rising. A consensus element that reacted to only one polarity would leave that word stuck.
- A fully packed chain with a producer still pushing. A wrong occupancy test would overwrite a held word or lose the pending one.
- Long random stretches with a slow and then a fast consumer. Wrong data or order when neighbouring stages fire back to back would show up here.

// File: rtl/mp_pkg.sv
package mp_pkg;

    // Phase of one consensus element; the value equals the phase wire level.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/mp_celement.sv
module mp_celement
    import mp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    output logic q_o,
    output logic fire_o
);

    phase_e state_q;
    phase_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: RISE on consensus of ones, FALL on consensus of zeros
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW: begin
                if (a_i && b_i) begin
                    state_d = PH_HIGH;
                end
            end
            PH_HIGH: begin
                if (!a_i && !b_i) begin
                    state_d = PH_LOW;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        q_o    = (state_q == PH_HIGH);
        fire_o = (state_d != state_q);
    end

    AST_CEL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i && b_i) |=> q_o);                                   // R2
    AST_CEL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_i && !b_i) |=> !q_o);                                // R2
    AST_CEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_i != b_i) |=> $stable(q_o));                          // R2

endmodule

// File: rtl/mp_stage.sv
module mp_stage
    import mp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             ack_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             phase_o,
    output logic [WIDTH-1:0] data_o
);

    logic             ack_n_w;
    logic             fire_w;
    logic [WIDTH-1:0] data_q;

    // The successor phase enters the consensus element inverted
    assign ack_n_w = ~ack_i;

    mp_celement u_cel (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_i    (req_i),
        .b_i    (ack_n_w),
        .q_o    (phase_o),
        .fire_o (fire_w)
    );

    // Data register loads on the same edge as the phase change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (fire_w) begin
            data_q <= data_i;
        end
    end

    assign data_o = data_q;

    AST_STAGE_FIRE_COND: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> (($past(req_i) != $past(phase_o)) &&
                               ($past(ack_i) == $past(phase_o))));  // R3
    AST_STAGE_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != ack_i) |=> $stable(data_o));                 // R6

endmodule

// File: rtl/mp_chain.sv
module mp_chain
    import mp_pkg::*;
#(
    parameter int STAGES = 4,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_req,
    input  logic [WIDTH-1:0] in_data,
    output logic             in_ack,
    output logic             out_req,
    output logic [WIDTH-1:0] out_data,
    input  logic             out_ack
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] phase_w;
    logic [STAGES-1:0] occ_w;
    logic [WIDTH-1:0]  word_w [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic             req_w;
        logic             ack_w;
        logic [WIDTH-1:0] din_w;

        if (i == 0) begin : g_head
            assign req_w = in_req;
            assign din_w = in_data;
        end else begin : g_body
            assign req_w = phase_w[i-1];
            assign din_w = word_w[i-1];
        end

        if (i == LAST) begin : g_tail
            assign ack_w = out_ack;
        end else begin : g_inner
            assign ack_w = phase_w[i+1];
        end

        // Token present when own phase differs from successor phase
        assign occ_w[i] = phase_w[i] ^ ack_w;

        mp_stage #(
            .WIDTH (WIDTH)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_i   (req_w),
            .ack_i   (ack_w),
            .data_i  (din_w),
            .phase_o (phase_w[i]),
            .data_o  (word_w[i])
        );

        if (i < LAST) begin : g_adj_chk
            AST_NO_ADJ_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(phase_w[i]) |-> $stable(phase_w[i+1]));  // R3
        end
    end

    assign in_ack   = phase_w[0];
    assign out_req  = phase_w[LAST];
    assign out_data = word_w[LAST];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (&occ_w) |=> $stable(in_ack));                           // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_w == '0) |=> $stable(out_req));                     // R8
    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != out_ack) |=> $stable(out_req));              // R6

endmodule

// File: tb/test_mp_chain.sv
module test_mp_chain;

    localparam int STAGES = 4;
    localparam int WIDTH  = 8;
    localparam int LAST   = STAGES - 1;

    logic             clk     = 1'b0;
    logic             rst_n   = 1'b0;
    logic             in_req  = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             out_ack = 1'b0;
    logic             in_ack;
    logic             out_req;
    logic [WIDTH-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int seq    = 1;

    // Behavioural token/bubble model
    bit               m_occ [STAGES];
    logic [WIDTH-1:0] m_val [STAGES];
    logic             m_in_ack  = 1'b0;
    logic             m_out_req = 1'b0;
    logic [WIDTH-1:0] sent_q [$];

    always #2 clk = ~clk;   // 250 MHz

    mp_chain #(
        .STAGES (STAGES),
        .WIDTH  (WIDTH)
    ) i_mp_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_req   (in_req),
        .in_data  (in_data),
        .in_ack   (in_ack),
        .out_req  (out_req),
        .out_data (out_data),
        .out_ack  (out_ack)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: compare at negedge, drive inputs, advance the model
    task automatic step(input bit pe, input bit ce);
        bit               f [STAGES];
        logic [WIDTH-1:0] exp_w;
        @(negedge clk);
        check(in_ack === m_in_ack, "R4", "in_ack", in_ack, m_in_ack);
        check(out_req === m_out_req, "R3", "out_req", out_req, m_out_req);
        check(out_data === m_val[LAST], "R6", "out_data", out_data, m_val[LAST]);
        if (ce && m_occ[LAST]) begin
            exp_w = (sent_q.size() > 0) ? sent_q[0] : '0;
            check(sent_q.size() > 0 && out_data === exp_w, "R9", "delivered word",
                  out_data, exp_w);
            if (sent_q.size() > 0) void'(sent_q.pop_front());
            out_ack     = ~out_ack;
            m_occ[LAST] = 1'b0;
        end
        if (pe && (in_req == m_in_ack)) begin
            in_data = WIDTH'(seq);
            seq++;
            sent_q.push_back(in_data);
            in_req = ~in_req;
        end
        f[0] = (in_req != m_in_ack) && !m_occ[0];
        for (int i = 1; i < STAGES; i++) f[i] = m_occ[i-1] && !m_occ[i];
        for (int i = LAST; i >= 0; i--) begin
            if (f[i]) begin
                m_occ[i] = 1'b1;
                if (i == 0) begin
                    m_val[i] = in_data;
                end else begin
                    m_val[i]   = m_val[i-1];
                    m_occ[i-1] = 1'b0;
                end
            end
        end
        if (f[0])    m_in_ack  = ~m_in_ack;
        if (f[LAST]) m_out_req = ~m_out_req;
    endtask

    initial begin
        int   lat_ack;
        int   lat_out;
        logic held_ack;
        for (int i = 0; i < STAGES; i++) begin
            m_occ[i] = 1'b0;
            m_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        check(in_ack === 1'b0, "R1", "in_ack at reset", in_ack, 0);
        check(out_req === 1'b0, "R1", "out_req at reset", out_req, 0);
        check(out_data === '0, "R1", "out_data at reset", out_data, 0);
        rst_n = 1'b1;

        // Underflow: consumer waits on an empty chain
        repeat (8) step(1'b0, 1'b1);
        check(out_req === 1'b0, "R8", "out_req while empty", out_req, 0);

        // Latency of a single word through the empty chain
        step(1'b1, 1'b0);
        lat_ack = -1;
        lat_out = -1;
        for (int k = 1; k <= 2 * STAGES; k++) begin
            step(1'b0, 1'b0);
            if (lat_ack < 0 && in_ack === in_req) lat_ack = k;
            if (lat_out < 0 && out_req === 1'b1) lat_out = k;
        end
        check(lat_ack == 1, "R4", "edges to in_ack toggle", lat_ack, 1);
        check(lat_out == STAGES, "R5", "edges to out_req toggle", lat_out, STAGES);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);

        // Second word uses a falling request; the phase must fall too
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check(in_ack === 1'b0, "R2", "in_ack after falling request", in_ack, 0);
        repeat (3 * STAGES) step(1'b0, 1'b1);
        check(sent_q.size() == 0, "R9", "words left after drain", sent_q.size(), 0);

        // Overflow: producer pushes, consumer idle
        repeat (3 * STAGES) step(1'b1, 1'b0);
        check(in_req !== in_ack, "R7", "request pending when full", in_req, ~in_ack);
        held_ack = in_ack;
        repeat (6) step(1'b1, 1'b0);
        check(in_ack === held_ack, "R7", "in_ack stable when full", in_ack, held_ack);
        check(sent_q.size() == STAGES + 1, "R7", "words held plus pending",
              sent_q.size(), STAGES + 1);
        repeat (4 * STAGES) step(1'b0, 1'b1);
        check(sent_q.size() == 0, "R9", "words left after full drain", sent_q.size(), 0);
        check(out_req === out_ack, "R8", "chain empty after drain", out_req, out_ack);

        // Random traffic, slow then fast consumer
        repeat (1500) step($urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0);
        repeat (1500) step($urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0);
        repeat (4 * STAGES) step(1'b0, 1'b1);
        check(sent_q.size() == 0, "R9", "words left after random run", sent_q.size(), 0);
        check(out_req === out_ack, "R8", "empty after random run", out_req, out_ack);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule